// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the byte-level command engine of a serial NOR flash slave. An SPI shift front end hands it one received byte per transfer strobe, and it answers each transfer with one response byte a cycle later. A separate one-cycle pulse marks each new chip-select assertion. The first byte of a selection is taken as an opcode. Depending on the opcode, the sequencer then gathers address, mode and dummy bytes, streams array contents from a combinational read port, or forwards bytes to the array engine as program requests. It also raises erase requests, holds the write-enable latch, and answers status and identification queries.

All read variants move data one byte per transfer; the dual and quad variants differ only in how many bytes follow the opcode. For the two I/O-mode reads, that count depends on the manufacturer code parameter. The identification reply has three bytes, or five when a non-zero extended code is configured. The address width is a parameter between 9 and 24 bits, and the array is taken to be 2^ADDR_W bytes.

Top module: `spi_nor_cmd_seq`

## Requirements
- R1: After reset the sequencer is idle with the write-enable latch clear, `tx_valid`, `prog_req` and `erase_req` low, `tx_byte` 0x00 and `rd_addr` 0.
- R2: Opcodes 0x03, 0x02, 0xA2, 0x32, 0x20, 0x52 and 0xD8 take 3 further bytes, and 0x0B, 0x3B and 0x6B take 4. The address is the first three of those bytes, most significant first, truncated to ADDR_W bits.
- R3: With manufacturer code 0xEF or 0x01, opcode 0xBB takes 4 further bytes and 0xEB takes 6. With any other manufacturer code, they take 5 and 8 respectively.
- R4: After a read opcode has its bytes, each transfer returns `rd_data` at the current address and then advances the address by one. The address wraps from 2^ADDR_W-1 to 0.
- R5: After a program opcode has its bytes, each received byte produces a one-cycle `prog_req` carrying that byte and the current address, and the address then advances by one.
- R6: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns one status byte in which bit 1 is the latch and every other bit is 0, then returns to opcode decode.
- R7: Opcode 0x9F returns the manufacturer code, then the device code high byte, then its low byte. If the extended code is non-zero, its high byte and low byte follow. Decode then resumes.
- R8: Opcodes 0x20, 0x52 and 0xD8 raise `erase_req` after their last address byte, with `erase_kind` 0, 1 or 2 and the collected address, but only when the latch is set. Opcode 0xC7 raises `erase_req` with kind 3 and address 0 on the opcode byte itself, again only when the latch is set.
- R9: When the latch is set, opcode 0x01 takes one further byte and then clears the latch. When the latch is clear, 0x01 is ignored and the next byte is decoded as an opcode.
- R10: A `cs_start` pulse returns the sequencer to opcode decode and drops any partly gathered command, leaving the latch unchanged. A byte strobed in the same cycle is discarded and produces no response.
- R11: Opcode 0x00 and unassigned opcodes are ignored. The response byte is 0x00 for opcode, address, dummy and program transfers.
- R12: `tx_valid` pulses for exactly one cycle in the cycle after each accepted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_start | input | 1 | One-cycle pulse on chip-select assertion |
| rx_valid | input | 1 | Transfer strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Response byte valid |
| tx_byte | output | 8 | Response byte for the last transfer |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 8 | Array read data, combinational from rd_addr |
| prog_req | output | 1 | Program one byte |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Program data |
| erase_req | output | 1 | Erase request |
| erase_kind | output | 2 | 0 small block, 1 medium block, 2 sector, 3 whole chip |
| erase_addr | output | ADDR_W | Erase address |

## Verification
The hardest cases to reach are the ones where the byte count after the opcode is decided by elaboration-time identity, because one instance cannot exercise both branches. The bench therefore runs two instances with different manufacturer and extended codes side by side and steers the strobes to one or the other. It finds the boundary of the address and dummy phase by checking that the first data byte comes out exactly one transfer after the last gathered byte. Address wrap is reached by loading the top address directly through a read command. Collision of a chip-select pulse with a byte strobe is forced by driving both in the same cycle.

// File: rtl/spi_nor_seq_pkg.sv
package spi_nor_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_COLLECT,
    SQ_PROGRAM,
    SQ_READ,
    SQ_REPLY
  } sq_state_t;

  typedef enum logic [3:0] {
    OK_NONE,
    OK_READ,
    OK_PROG,
    OK_ERASE,
    OK_WSTAT,
    OK_WEN,
    OK_WDIS,
    OK_STAT,
    OK_IDENT,
    OK_CHIP
  } op_kind_t;

  localparam logic [1:0] ERK_SMALL = 2'd0;
  localparam logic [1:0] ERK_MED   = 2'd1;
  localparam logic [1:0] ERK_SECT  = 2'd2;
  localparam logic [1:0] ERK_CHIP  = 2'd3;

  // manufacturers that use the shorter I/O-mode read preamble
  function automatic logic short_io_preamble(input logic [7:0] mfr);
    return (mfr == 8'hEF) || (mfr == 8'h01);
  endfunction

  function automatic logic [3:0] dual_io_len(input logic [7:0] mfr);
    return short_io_preamble(mfr) ? 4'd4 : 4'd5;
  endfunction

  function automatic logic [3:0] quad_io_len(input logic [7:0] mfr);
    return short_io_preamble(mfr) ? 4'd6 : 4'd8;
  endfunction

  function automatic logic [2:0] ident_len(input logic [15:0] ext);
    return (ext != 16'h0000) ? 3'd5 : 3'd3;
  endfunction

  function automatic logic [7:0] status_byte(input logic wel);
    return {6'b000000, wel, 1'b0};
  endfunction

endpackage

// File: rtl/spi_nor_op_decode.sv
module spi_nor_op_decode
  import spi_nor_seq_pkg::*;
#(
  parameter logic [7:0] MFR_ID = 8'h20
) (
  input  logic [7:0] op,
  output op_kind_t   kind,
  output logic [3:0] need,
  output logic [1:0] er_kind
);

  always_comb begin
    kind    = OK_NONE;
    need    = 4'd0;
    er_kind = ERK_SMALL;
    case (op)
      8'h03:               begin kind = OK_READ;  need = 4'd3; end
      8'h0B, 8'h3B, 8'h6B: begin kind = OK_READ;  need = 4'd4; end
      8'hBB:               begin kind = OK_READ;  need = dual_io_len(MFR_ID); end
      8'hEB:               begin kind = OK_READ;  need = quad_io_len(MFR_ID); end
      8'h02, 8'hA2, 8'h32: begin kind = OK_PROG;  need = 4'd3; end
      8'h20: begin kind = OK_ERASE; need = 4'd3; er_kind = ERK_SMALL; end
      8'h52: begin kind = OK_ERASE; need = 4'd3; er_kind = ERK_MED;   end
      8'hD8: begin kind = OK_ERASE; need = 4'd3; er_kind = ERK_SECT;  end
      8'h01:               begin kind = OK_WSTAT; need = 4'd1; end
      8'h06:               kind = OK_WEN;
      8'h04:               kind = OK_WDIS;
      8'h05:               kind = OK_STAT;
      8'h9F:               kind = OK_IDENT;
      8'hC7:               begin kind = OK_CHIP; er_kind = ERK_CHIP; end
      default:             kind = OK_NONE;
    endcase
  end

endmodule

// File: rtl/spi_nor_reply_gen.sv
module spi_nor_reply_gen
  import spi_nor_seq_pkg::*;
#(
  parameter logic [7:0]  MFR_ID = 8'h20,
  parameter logic [15:0] DEV_ID = 16'h2014,
  parameter logic [15:0] EXT_ID = 16'h0000
) (
  input  logic       is_ident,
  input  logic [2:0] pos,
  input  logic       wel,
  output logic [7:0] byte_o,
  output logic [2:0] len
);

  logic [7:0] id_byte;

  always_comb begin
    case (pos)
      3'd0:    id_byte = MFR_ID;
      3'd1:    id_byte = DEV_ID[15:8];
      3'd2:    id_byte = DEV_ID[7:0];
      3'd3:    id_byte = EXT_ID[15:8];
      3'd4:    id_byte = EXT_ID[7:0];
      default: id_byte = 8'h00;
    endcase
  end

  assign byte_o = is_ident ? id_byte : status_byte(wel);
  assign len    = is_ident ? ident_len(EXT_ID) : 3'd1;

endmodule

// File: rtl/spi_nor_cmd_seq.sv
module spi_nor_cmd_seq
  import spi_nor_seq_pkg::*;
#(
  parameter int          ADDR_W = 20,
  parameter logic [7:0]  MFR_ID = 8'h20,
  parameter logic [15:0] DEV_ID = 16'h2014,
  parameter logic [15:0] EXT_ID = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_start,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              erase_req,
  output logic [1:0]        erase_kind,
  output logic [ADDR_W-1:0] erase_addr
);

  localparam int CNT_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  sq_state_t          state_q;
  op_kind_t           kind_q;
  logic [1:0]         erk_q;
  logic [CNT_W-1:0]   need_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  abuf_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               wel_q;
  logic               rep_ident_q;
  logic [2:0]         pos_q;

  // named events for the checker
  logic               xfer;
  logic               collect_last;
  logic [ADDR_W-1:0]  addr_full;

  op_kind_t           dec_kind;
  logic [CNT_W-1:0]   dec_need;
  logic [1:0]         dec_erk;
  logic [7:0]         rep_byte;
  logic [2:0]         rep_len;

  spi_nor_op_decode #(.MFR_ID(MFR_ID)) u_dec (
    .op      (rx_byte),
    .kind    (dec_kind),
    .need    (dec_need),
    .er_kind (dec_erk)
  );

  spi_nor_reply_gen #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .EXT_ID(EXT_ID)) u_rep (
    .is_ident (rep_ident_q),
    .pos      (pos_q),
    .wel      (wel_q),
    .byte_o   (rep_byte),
    .len      (rep_len)
  );

  assign xfer         = rx_valid && !cs_start;
  assign collect_last = xfer && (state_q == SQ_COLLECT) &&
                        ((cnt_q + 1'b1) == need_q);
  assign addr_full    = (cnt_q == 4'd2) ? {abuf_q[ADDR_W-9:0], rx_byte} : abuf_q;
  assign rd_addr      = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      kind_q      <= OK_NONE;
      erk_q       <= ERK_SMALL;
      need_q      <= '0;
      cnt_q       <= '0;
      abuf_q      <= '0;
      addr_q      <= '0;
      wel_q       <= 1'b0;
      rep_ident_q <= 1'b0;
      pos_q       <= '0;
      tx_valid    <= 1'b0;
      tx_byte     <= 8'h00;
      prog_req    <= 1'b0;
      prog_addr   <= '0;
      prog_data   <= 8'h00;
      erase_req   <= 1'b0;
      erase_kind  <= ERK_SMALL;
      erase_addr  <= '0;
    end else begin
      tx_valid  <= 1'b0;
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      if (cs_start) begin
        state_q <= SQ_IDLE;
        cnt_q   <= '0;
        pos_q   <= '0;
      end else if (rx_valid) begin
        tx_valid <= 1'b1;
        tx_byte  <= 8'h00;
        case (state_q)
          SQ_IDLE: begin
            kind_q <= dec_kind;
            erk_q  <= dec_erk;
            need_q <= dec_need;
            cnt_q  <= '0;
            abuf_q <= '0;
            case (dec_kind)
              OK_READ, OK_PROG, OK_ERASE: state_q <= SQ_COLLECT;
              OK_WSTAT: if (wel_q) state_q <= SQ_COLLECT;
              OK_WEN:   wel_q <= 1'b1;
              OK_WDIS:  wel_q <= 1'b0;
              OK_STAT: begin
                rep_ident_q <= 1'b0;
                pos_q       <= '0;
                state_q     <= SQ_REPLY;
              end
              OK_IDENT: begin
                rep_ident_q <= 1'b1;
                pos_q       <= '0;
                state_q     <= SQ_REPLY;
              end
              OK_CHIP: if (wel_q) begin
                erase_req  <= 1'b1;
                erase_kind <= ERK_CHIP;
                erase_addr <= '0;
              end
              default: ;
            endcase
          end
          SQ_COLLECT: begin
            if (cnt_q < 4'd3) abuf_q <= {abuf_q[ADDR_W-9:0], rx_byte};
            cnt_q <= cnt_q + 1'b1;
            if (collect_last) begin
              addr_q  <= addr_full;
              state_q <= SQ_IDLE;
              case (kind_q)
                OK_READ:  state_q <= SQ_READ;
                OK_PROG:  state_q <= SQ_PROGRAM;
                OK_ERASE: if (wel_q) begin
                  erase_req  <= 1'b1;
                  erase_kind <= erk_q;
                  erase_addr <= addr_full;
                end
                OK_WSTAT: wel_q <= 1'b0;
                default: ;
              endcase
            end
          end
          SQ_READ: begin
            tx_byte <= rd_data;
            addr_q  <= addr_q + ADDR_ONE;
          end
          SQ_PROGRAM: begin
            prog_req  <= 1'b1;
            prog_addr <= addr_q;
            prog_data <= rx_byte;
            addr_q    <= addr_q + ADDR_ONE;
          end
          SQ_REPLY: begin
            tx_byte <= rep_byte;
            pos_q   <= pos_q + 3'd1;
            if ((pos_q + 3'd1) == rep_len) begin
              pos_q   <= '0;
              state_q <= SQ_IDLE;
            end
          end
          default: state_q <= SQ_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_nor_cmd_seq_chk.sv
module spi_nor_cmd_seq_chk
  import spi_nor_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_start,
  input logic              xfer,
  input logic [2:0]        state,
  input logic              collect_last,
  input logic [3:0]        kind,
  input logic              wel,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rx_byte,
  input logic              tx_valid,
  input logic              prog_req,
  input logic [7:0]        prog_data,
  input logic              erase_req
);

  localparam logic [ADDR_W-1:0] STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

  AST_CS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> (state == SQ_IDLE)); // R10

  AST_ERASE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(wel)); // R8

  AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && state == SQ_READ) |=> (rd_addr == $past(rd_addr) + STEP)); // R4

  AST_PROG_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> ($past(state) == SQ_PROGRAM && prog_data == $past(rx_byte))); // R5

  AST_TX_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> tx_valid); // R12

  AST_TX_ONLY_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(xfer)); // R12

  AST_WSTAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (collect_last && kind == OK_WSTAT) |=> !wel); // R9

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, erase_req})); // R11

endmodule

bind spi_nor_cmd_seq spi_nor_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_start     (cs_start),
  .xfer         (xfer),
  .state        (state_q),
  .collect_last (collect_last),
  .kind         (kind_q),
  .wel          (wel_q),
  .rd_addr      (rd_addr),
  .rx_byte      (rx_byte),
  .tx_valid     (tx_valid),
  .prog_req     (prog_req),
  .prog_data    (prog_data),
  .erase_req    (erase_req)
);

// File: tb/test_spi_nor_cmd_seq.sv
module test_spi_nor_cmd_seq;

  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_start = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic sel = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // DUT A: manufacturer 0x20, no extended code; DUT B: 0xEF with extended code
  logic cs_a, cs_b, v_a, v_b;
  assign cs_a = cs_start && !sel;
  assign cs_b = cs_start && sel;
  assign v_a  = rx_valid && !sel;
  assign v_b  = rx_valid && sel;

  logic tv_a, tv_b, pr_a, pr_b, er_a, er_b;
  logic [7:0] tx_a, tx_b, pd_a, pd_b, rdd_a, rdd_b;
  logic [AW-1:0] ra_a, ra_b, pa_a, pa_b, ea_a, ea_b;
  logic [1:0] ek_a, ek_b;

  assign rdd_a = ra_a[7:0] ^ 8'h5A;
  assign rdd_b = ra_b[7:0] ^ 8'h5A;

  spi_nor_cmd_seq #(.ADDR_W(AW), .MFR_ID(8'h20), .DEV_ID(16'h2014), .EXT_ID(16'h0000))
  i_spi_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cs_start(cs_a), .rx_valid(v_a), .rx_byte(rx_byte),
    .tx_valid(tv_a), .tx_byte(tx_a), .rd_addr(ra_a), .rd_data(rdd_a),
    .prog_req(pr_a), .prog_addr(pa_a), .prog_data(pd_a),
    .erase_req(er_a), .erase_kind(ek_a), .erase_addr(ea_a));

  spi_nor_cmd_seq #(.ADDR_W(AW), .MFR_ID(8'hEF), .DEV_ID(16'h4017), .EXT_ID(16'h4D01))
  i_spi_nor_cmd_seq_alt (
    .clk(clk), .rst_n(rst_n), .cs_start(cs_b), .rx_valid(v_b), .rx_byte(rx_byte),
    .tx_valid(tv_b), .tx_byte(tx_b), .rd_addr(ra_b), .rd_data(rdd_b),
    .prog_req(pr_b), .prog_addr(pa_b), .prog_data(pd_b),
    .erase_req(er_b), .erase_kind(ek_b), .erase_addr(ea_b));

  // {select pulse first, byte sent, expected response}, on DUT A
  localparam int NV = 56;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1,8'h9F,8'h00}, {1'b0,8'h00,8'h20}, {1'b0,8'h00,8'h20}, {1'b0,8'h00,8'h14},
    {1'b0,8'h05,8'h00}, {1'b0,8'h00,8'h00},
    {1'b1,8'h06,8'h00}, {1'b1,8'h05,8'h00}, {1'b0,8'h00,8'h02},
    {1'b1,8'h04,8'h00}, {1'b1,8'h05,8'h00}, {1'b0,8'h00,8'h00},
    {1'b1,8'h03,8'h00}, {1'b0,8'h00,8'h00}, {1'b0,8'h01,8'h00}, {1'b0,8'h10,8'h00},
    {1'b0,8'h00,8'h4A}, {1'b0,8'h00,8'h4B},
    {1'b1,8'h0B,8'h00}, {1'b0,8'h00,8'h00}, {1'b0,8'h00,8'h00}, {1'b0,8'h20,8'h00},
    {1'b0,8'hA5,8'h00}, {1'b0,8'h00,8'h7A},
    {1'b1,8'h3B,8'h00}, {1'b0,8'h00,8'h00}, {1'b0,8'h00,8'h00}, {1'b0,8'h50,8'h00},
    {1'b0,8'hA5,8'h00}, {1'b0,8'h00,8'h0A},
    {1'b1,8'hBB,8'h00}, {1'b0,8'h00,8'h00}, {1'b0,8'h00,8'h00}, {1'b0,8'h30,8'h00},
    {1'b0,8'h11,8'h00}, {1'b0,8'h22,8'h00}, {1'b0,8'h00,8'h6A},
    {1'b1,8'hEB,8'h00}, {1'b0,8'h00,8'h00}, {1'b0,8'h00,8'h00}, {1'b0,8'h40,8'h00},
    {1'b0,8'h33,8'h00}, {1'b0,8'h33,8'h00}, {1'b0,8'h33,8'h00}, {1'b0,8'h33,8'h00},
    {1'b0,8'h33,8'h00}, {1'b0,8'h00,8'h1A},
    {1'b1,8'h6B,8'h00}, {1'b0,8'h00,8'h00}, {1'b0,8'h00,8'h00}, {1'b0,8'h60,8'h00},
    {1'b0,8'hA5,8'h00}, {1'b0,8'h00,8'h3A},
    {1'b1,8'hFF,8'h00}, {1'b0,8'h05,8'h00}, {1'b0,8'h00,8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // optional select pulse, then one transfer; returns at the negedge after
  // the strobe edge, where the registered outputs show its result
  task automatic send(input logic cs, input logic [7:0] b);
    if (cs) begin
      @(negedge clk) cs_start = 1'b1;
      @(negedge clk) cs_start = 1'b0;
    end
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [7:0] cur_tx();
    return sel ? tx_b : tx_a;
  endfunction

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_valid", {31'b0, tv_a}, 32'd0);
    check("R1 tx_byte", {24'b0, tx_a}, 32'd0);
    check("R1 prog_req", {31'b0, pr_a}, 32'd0);
    check("R1 erase_req", {31'b0, er_a}, 32'd0);
    check("R1 rd_addr", {12'b0, ra_a}, 32'd0);

    // vector table: R2 R3 R4 R6 R7 R11 R12
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][16], VEC[i][15:8]);
      check($sformatf("R2/R4/R6/R7/R11 vec %0d", i), {24'b0, tx_a}, {24'b0, VEC[i][7:0]});
      check("R12 tx_valid", {31'b0, tv_a}, 32'd1);
    end
    @(negedge clk);
    check("R12 single pulse", {31'b0, tv_a}, 32'd0);

    // R5 program stream
    send(1'b1, 8'h02); send(1'b0, 8'h00); send(1'b0, 8'h01); send(1'b0, 8'h00);
    check("R5 no early prog", {31'b0, pr_a}, 32'd0);
    send(1'b0, 8'hAB);
    check("R5 prog_req", {31'b0, pr_a}, 32'd1);
    check("R5 prog_addr", {12'b0, pa_a}, 32'h100);
    check("R5 prog_data", {24'b0, pd_a}, 32'hAB);
    check("R11 prog resp", {24'b0, tx_a}, 32'h00);
    send(1'b0, 8'hCD);
    check("R5 prog_addr next", {12'b0, pa_a}, 32'h101);
    check("R5 prog_data next", {24'b0, pd_a}, 32'hCD);

    // R8 erases with and without latch
    send(1'b1, 8'h06);
    send(1'b1, 8'h20); send(1'b0, 8'h01); send(1'b0, 8'h23);
    check("R8 no early erase", {31'b0, er_a}, 32'd0);
    send(1'b0, 8'h45);
    check("R8 erase small", {31'b0, er_a}, 32'd1);
    check("R8 kind small", {30'b0, ek_a}, 32'd0);
    check("R8 erase addr", {12'b0, ea_a}, 32'h12345);
    send(1'b1, 8'h52); send(1'b0, 8'h00); send(1'b0, 8'h80); send(1'b0, 8'h00);
    check("R8 kind medium", {30'b0, ek_a}, 32'd1);
    send(1'b1, 8'hD8); send(1'b0, 8'h0F); send(1'b0, 8'h00); send(1'b0, 8'h00);
    check("R8 kind sector", {30'b0, ek_a}, 32'd2);
    check("R8 sector addr", {12'b0, ea_a}, 32'hF0000);
    send(1'b1, 8'hC7);
    check("R8 chip erase", {31'b0, er_a}, 32'd1);
    check("R8 chip kind", {30'b0, ek_a}, 32'd3);
    check("R8 chip addr", {12'b0, ea_a}, 32'd0);
    send(1'b1, 8'h04);
    send(1'b1, 8'hC7);
    check("R8 chip gated", {31'b0, er_a}, 32'd0);
    send(1'b1, 8'hD8); send(1'b0, 8'h00); send(1'b0, 8'h00); send(1'b0, 8'h00);
    check("R8 sector gated", {31'b0, er_a}, 32'd0);

    // R9 status write with and without latch
    send(1'b1, 8'h06);
    send(1'b1, 8'h01); send(1'b0, 8'h9F);
    send(1'b1, 8'h05); send(1'b0, 8'h00);
    check("R9 latch cleared", {24'b0, tx_a}, 32'h00);
    send(1'b1, 8'h01); send(1'b0, 8'h9F); send(1'b0, 8'h00);
    check("R9 ignored without latch", {24'b0, tx_a}, 32'h20);

    // R4 wrap at top of array
    send(1'b1, 8'h03); send(1'b0, 8'h0F); send(1'b0, 8'hFF); send(1'b0, 8'hFF);
    send(1'b0, 8'h00);
    check("R4 top byte", {24'b0, tx_a}, 32'hA5);
    send(1'b0, 8'h00);
    check("R4 wrapped byte", {24'b0, tx_a}, 32'h5A);
    check("R4 wrapped addr", {12'b0, ra_a}, 32'h1);

    // R10 select drops partial command; collision discards byte
    send(1'b1, 8'h03); send(1'b0, 8'h00);
    send(1'b1, 8'h9F); send(1'b0, 8'h00);
    check("R10 partial dropped", {24'b0, tx_a}, 32'h20);
    @(negedge clk);
    cs_start = 1'b1; rx_valid = 1'b1; rx_byte = 8'h06;
    @(negedge clk);
    cs_start = 1'b0; rx_valid = 1'b0;
    check("R10 collision no response", {31'b0, tv_a}, 32'd0);
    send(1'b0, 8'h05); send(1'b0, 8'h00);
    check("R10 collision byte discarded", {24'b0, tx_a}, 32'h00);
    send(1'b1, 8'h06);
    send(1'b1, 8'h05); send(1'b0, 8'h00);
    check("R10 latch kept across select", {24'b0, tx_a}, 32'h02);

    // alternate instance: R3 short preamble, R7 five-byte ident
    sel = 1'b1;
    send(1'b1, 8'h9F);
    send(1'b0, 8'h00); check("R7 ext b0", {24'b0, cur_tx()}, 32'hEF);
    send(1'b0, 8'h00); check("R7 ext b1", {24'b0, cur_tx()}, 32'h40);
    send(1'b0, 8'h00); check("R7 ext b2", {24'b0, cur_tx()}, 32'h17);
    send(1'b0, 8'h00); check("R7 ext b3", {24'b0, cur_tx()}, 32'h4D);
    send(1'b0, 8'h00); check("R7 ext b4", {24'b0, cur_tx()}, 32'h01);
    send(1'b0, 8'h05); send(1'b0, 8'h00);
    check("R7 idle after ext reply", {24'b0, cur_tx()}, 32'h00);
    send(1'b1, 8'hBB); send(1'b0, 8'h00); send(1'b0, 8'h00); send(1'b0, 8'h30);
    send(1'b0, 8'h77);
    send(1'b0, 8'h00);
    check("R3 dual io short", {24'b0, cur_tx()}, 32'h6A);
    send(1'b1, 8'hEB); send(1'b0, 8'h00); send(1'b0, 8'h00); send(1'b0, 8'h40);
    send(1'b0, 8'h77); send(1'b0, 8'h77); send(1'b0, 8'h77);
    send(1'b0, 8'h00);
    check("R3 quad io short", {24'b0, cur_tx()}, 32'h1A);
    sel = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule